// File: doc/BRIEF.md
# Pseudo-SRAM Access Sequencer

This block sits between a synchronous host and a 256K x 8 non-volatile memory that exposes an asynchronous, SRAM-like strobe interface. The host hands over one single-beat request at a time, either a read or a write, through a valid/ready handshake. The block turns each request into a timed pin sequence toward the memory. The memory captures its address when chip select becomes active, so the address must settle before select is asserted. Every access ends with a deselected precharge interval that has to expire before the next access may start.

Each access walks through five phases. In setup the address is presented with the chip deselected. In the strobe phase the chip is selected and either the read or the write strobe is active. In the hold phase the strobe is released and the chip stays selected. In precharge the chip is deselected again, and the sequencer then returns to idle. Setup, strobe, hold and precharge each last a parameterized number of clock cycles. The data bus is split into an outgoing byte, an incoming byte and a driver enable, so the pad ring can build the bidirectional pin from them. Read data is captured in a register and announced with a single-cycle valid pulse.

Top module: `psram_seq`

## Requirements
- R1: Out of reset, both selects are inactive (memCe1N=1, memCe2=0), both strobes are high (memWeN=1, memOeN=1), memDqOutEn=0, rdValid=0 and reqReady=1.
- R2: A request is taken on a clock edge where reqValid and reqReady are both 1. reqReady stays 0 for exactly SETUP_CYC+ACCESS_CYC+HOLD_CYC+PRE_CYC cycles after that edge, and reqValid is ignored during this time.
- R3: From the cycle after acceptance until the end of the hold phase, memAddr equals the accepted address and does not change. The chip is selected (memCe1N=0 and memCe2=1) only after SETUP_CYC cycles of setup, and stays selected for exactly ACCESS_CYC+HOLD_CYC cycles.
- R4: For a read (reqWrite=0), memOeN is 0 for exactly the ACCESS_CYC cycles of the strobe phase and memWeN stays 1. The byte on memDqIn in the last strobe cycle appears on rdData, and rdValid is 1 for exactly one cycle, the first cycle of the hold phase.
- R5: For a write (reqWrite=1), memWeN is 0 for exactly ACCESS_CYC cycles and memOeN stays 1. memDqOutEn is 1, with memDqOut equal to the accepted data, through setup, strobe and hold. It is 0 in precharge and in idle.
- R6: memDqOutEn is never 1 while memOeN is 0, and it is never set during a read access.
- R7: Between the end of one select window and the start of the next, the chip stays deselected for at least PRE_CYC cycles. For back-to-back requests this gap is exactly PRE_CYC+1+SETUP_CYC cycles.
- R8: memWeN and memOeN are never both 0, and neither is 0 unless the chip is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 8 | Write byte |
| rdValid | output | 1 | One-cycle pulse, rdData holds read byte |
| rdData | output | 8 | Captured read byte |
| memCe1N | output | 1 | Chip select, active low |
| memCe2 | output | 1 | Chip select, active high |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Read strobe, active low |
| memAddr | output | 18 | Memory address bus |
| memDqOut | output | 8 | Byte to drive onto the data pins |
| memDqOutEn | output | 1 | Enable for the data-pin driver |
| memDqIn | input | 8 | Byte sampled from the data pins |

## Verification
The bench builds the sequencer with SETUP_CYC=1, ACCESS_CYC=3, HOLD_CYC=1 and PRE_CYC=2, so a full access lasts seven cycles. With accesses this short, every pin can be compared in every cycle of every access against the phase the bench computes from the cycle index. A behavioural memory model in the bench stores bytes on the write strobe's rising edge and returns an address-derived pattern for locations never written. The sweep covers writes and reads at corner and mixed addresses, back-to-back requests with reqValid left high, and noise on the request inputs while the sequencer is busy.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACCESS, ST_HOLD, ST_PRE
  } seqState_t;

  typedef struct packed {
    logic captureReq;
    logic sampleRd;
    logic driveBus;
  } seqStrobes_t;
endpackage

// File: rtl/psram_seq_ctrl.sv
module psram_seq_ctrl
  import psram_seq_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int ACCESS_CYC = 16,
  parameter int HOLD_CYC   = 2,
  parameter int PRE_CYC    = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output logic        memCe1N,
  output logic        memCe2,
  output logic        memWeN,
  output logic        memOeN,
  output seqStrobes_t strobes
);
  localparam int MAX_AB  = (SETUP_CYC > ACCESS_CYC) ? SETUP_CYC : ACCESS_CYC;
  localparam int MAX_CD  = (HOLD_CYC > PRE_CYC) ? HOLD_CYC : PRE_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             isWrite;
  logic             selActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state   <= ST_SETUP;
          cnt     <= CNT_W'(SETUP_CYC - 1);
          isWrite <= reqWrite;
        end
        ST_SETUP: if (cnt == '0) begin
          state <= ST_ACCESS;
          cnt   <= CNT_W'(ACCESS_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_ACCESS: if (cnt == '0) begin
          state <= ST_HOLD;
          cnt   <= CNT_W'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_HOLD: if (cnt == '0) begin
          state <= ST_PRE;
          cnt   <= CNT_W'(PRE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_PRE: if (cnt == '0) state <= ST_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady            = (state == ST_IDLE);
    selActive           = (state == ST_ACCESS) || (state == ST_HOLD);
    memCe1N             = !selActive;
    memCe2              = selActive;
    memWeN              = !((state == ST_ACCESS) && isWrite);
    memOeN              = !((state == ST_ACCESS) && !isWrite);
    strobes.captureReq  = (state == ST_IDLE) && reqValid;
    strobes.sampleRd    = (state == ST_ACCESS) && !isWrite && (cnt == '0);
    strobes.driveBus    = isWrite && ((state == ST_SETUP) ||
                          (state == ST_ACCESS) || (state == ST_HOLD));
  end

  // Counts deselected cycles, saturating at PRE_CYC, to check the precharge gap.
  logic [CNT_W-1:0] deselCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                            deselCnt <= CNT_W'(PRE_CYC);
    else if (selActive)                   deselCnt <= '0;
    else if (deselCnt < CNT_W'(PRE_CYC))  deselCnt <= deselCnt + 1'b1;
  end

  a_r7_precharge_gap: assert property (@(posedge clk) disable iff (!rstN)
    (selActive && !$past(selActive)) |-> (deselCnt >= CNT_W'(PRE_CYC)));
  a_r8_strobe_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN || !memOeN) |-> (!memCe1N && memCe2));
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN));
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
endmodule

// File: rtl/psram_seq_dp.sv
module psram_seq_dp
  import psram_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOutEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdReg;
  logic              rdValidReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg    <= '0;
      wdataReg   <= '0;
      rdReg      <= '0;
      rdValidReg <= 1'b0;
    end else begin
      if (strobes.captureReq) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (strobes.sampleRd) rdReg <= memDqIn;
      rdValidReg <= strobes.sampleRd;
    end
  end

  assign memAddr    = addrReg;
  assign memDqOut   = wdataReg;
  assign memDqOutEn = strobes.driveBus;
  assign rdData     = rdReg;
  assign rdValid    = rdValidReg;

  a_r4_rdvalid_single: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);
  a_r6_no_drive_on_read_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sampleRd |-> !memDqOutEn);
endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_seq_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int ACCESS_CYC = 16,
  parameter int HOLD_CYC   = 2,
  parameter int PRE_CYC    = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOutEn,
  input  logic [DATA_W-1:0] memDqIn
);
  seqStrobes_t strobes;

  psram_seq_ctrl #(
    .SETUP_CYC(SETUP_CYC), .ACCESS_CYC(ACCESS_CYC),
    .HOLD_CYC(HOLD_CYC), .PRE_CYC(PRE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .memCe1N(memCe1N), .memCe2(memCe2),
    .memWeN(memWeN), .memOeN(memOeN), .strobes(strobes)
  );

  psram_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memDqIn(memDqIn), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqOutEn(memDqOutEn), .rdData(rdData),
    .rdValid(rdValid)
  );

  logic selNow;
  assign selNow = !memCe1N && memCe2;

  a_r3_addr_stable_selected: assert property (@(posedge clk) disable iff (!rstN)
    (selNow && $past(selNow)) |-> $stable(memAddr));
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !(memDqOutEn && !memOeN));
  a_r5_drive_during_write_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDqOutEn);
endmodule

// File: tb/psram_seq_tb.sv
module psram_seq_tb;
  localparam int S = 1, A = 3, H = 1, P = 2;
  localparam int TOT = S + A + H + P;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic reqReady, rdValid, memCe1N, memCe2, memWeN, memOeN, memDqOutEn;
  logic [7:0]  rdData, memDqOut, memDqIn;
  logic [17:0] memAddr;

  always #4 clk = ~clk;

  psram_seq #(.SETUP_CYC(S), .ACCESS_CYC(A), .HOLD_CYC(H), .PRE_CYC(P)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .memCe1N(memCe1N), .memCe2(memCe2),
    .memWeN(memWeN), .memOeN(memOeN), .memAddr(memAddr), .memDqOut(memDqOut),
    .memDqOutEn(memDqOutEn), .memDqIn(memDqIn)
  );

  // Behavioural memory model
  logic [7:0] modelMem [int];
  logic [7:0] refMem [int];

  function automatic logic [7:0] fillPat(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'h5A;
  endfunction

  wire modelSel = !memCe1N && memCe2;
  always_comb begin
    if (modelSel && !memOeN && memWeN)
      memDqIn = modelMem.exists(int'(memAddr)) ? modelMem[int'(memAddr)] : fillPat(memAddr);
    else
      memDqIn = 8'hEE;
  end
  always @(posedge memWeN) begin
    if (modelSel && memDqOutEn) modelMem[int'(memAddr)] = memDqOut;
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doAccess(input bit wr, input logic [17:0] a, input logic [7:0] d,
                          input bit noise);
    logic [7:0] expRd;
    int lastSelEnd;
    expRd = refMem.exists(int'(a)) ? refMem[int'(a)] : fillPat(a);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    if (noise) begin reqAddr = ~a; reqWdata = ~d; reqWrite = !wr; end
    else reqValid = 1'b0;
    for (int k = 0; k < TOT; k++) begin
      bit inAcc, inSel, inPre;
      inAcc = (k >= S) && (k < S + A);
      inSel = (k >= S) && (k < S + A + H);
      inPre = (k >= S + A + H);
      chk(reqReady == 1'b0, "R2", "reqReady busy", reqReady, 0);
      chk((!memCe1N && memCe2) == inSel, "R3", "select window", !memCe1N && memCe2, inSel);
      if (!inPre) chk(memAddr == a, "R3", "address held", memAddr, a);
      chk(memOeN == !(inAcc && !wr), "R4", "oe strobe", memOeN, !(inAcc && !wr));
      chk(memWeN == !(inAcc && wr), "R5", "we strobe", memWeN, !(inAcc && wr));
      chk(memDqOutEn == (wr && !inPre), "R5", "driver enable", memDqOutEn, wr && !inPre);
      if (wr && !inPre) chk(memDqOut == d, "R5", "write byte", memDqOut, d);
      if (!memOeN) chk(!memDqOutEn, "R6", "contention", memDqOutEn, 0);
      chk(!(!memWeN && !memOeN), "R8", "both strobes", {memWeN, memOeN}, 3);
      chk(rdValid == (!wr && k == S + A), "R4", "rdValid pulse", rdValid, !wr && k == S + A);
      if (!wr && k == S + A) chk(rdData == expRd, "R4", "read byte", rdData, expRd);
      if (noise && k == TOT - 1) reqValid = 1'b0;
      @(negedge clk);
    end
    chk(reqReady == 1'b1, "R2", "ready after precharge", reqReady, 1);
    chk(memCe1N == 1'b1, "R7", "deselected in idle", memCe1N, 1);
    if (wr) refMem[int'(a)] = d;
  endtask

  // Back-to-back: keep reqValid high across two requests, measure deselected gap.
  task automatic backToBack(input logic [17:0] a0, input logic [17:0] a1);
    int gap, phase;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a0;
    gap = 0; phase = 0;
    for (int k = 0; k < 3 * TOT && phase < 3; k++) begin
      @(negedge clk);
      if (phase == 0 && modelSel) phase = 1;
      else if (phase == 1 && !modelSel) begin phase = 2; gap = 1; reqAddr = a1; end
      else if (phase == 2 && !modelSel) gap++;
      else if (phase == 2 && modelSel) begin
        phase = 3;
        chk(memAddr == a1, "R3", "second address", memAddr, a1);
      end
    end
    reqValid = 1'b0;
    chk(gap == P + 1 + S, "R7", "back-to-back gap", gap, P + 1 + S);
    chk(gap >= P, "R7", "minimum precharge", gap, P);
    repeat (TOT + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(memCe1N == 1 && memCe2 == 0, "R1", "reset selects", {memCe1N, memCe2}, 2);
    chk(memWeN == 1 && memOeN == 1, "R1", "reset strobes", {memWeN, memOeN}, 3);
    chk(memDqOutEn == 0 && rdValid == 0, "R1", "reset driver/valid", {memDqOutEn, rdValid}, 0);
    chk(reqReady == 1, "R1", "reset ready", reqReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    // reads of untouched locations
    doAccess(1'b0, 18'h00000, 8'h00, 1'b0);
    doAccess(1'b0, 18'h3FFFF, 8'h00, 1'b0);
    // writes then read back at corner and mixed addresses
    for (int i = 0; i < 8; i++) begin
      logic [17:0] a;
      a = 18'(i * 37449) ^ 18'(1 << (i * 2));
      doAccess(1'b1, a, 8'(i * 29 + 3), i[0]);
    end
    doAccess(1'b1, 18'h3FFFF, 8'hA5, 1'b0);
    doAccess(1'b1, 18'h00000, 8'h3C, 1'b1);
    for (int i = 0; i < 8; i++) begin
      logic [17:0] a;
      a = 18'(i * 37449) ^ 18'(1 << (i * 2));
      doAccess(1'b0, a, 8'h00, !i[0]);
    end
    doAccess(1'b0, 18'h3FFFF, 8'h00, 1'b0);
    doAccess(1'b0, 18'h00000, 8'h00, 1'b0);
    // overwrite then read, same address
    doAccess(1'b1, 18'h12345, 8'hFF, 1'b0);
    doAccess(1'b1, 18'h12345, 8'h01, 1'b0);
    doAccess(1'b0, 18'h12345, 8'h00, 1'b0);
    backToBack(18'h0AAAA, 18'h15555);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule